// File: doc/BRIEF.md
# Flow-Through Byte-Write SRAM Core

This block is a synchronous single-port memory of 36-bit words. Each word holds four 8-bit data lanes in bits [31:0] and one parity bit per lane in bits [35:32]. The depth is a parameter. A burst address generator outside the block supplies the word address every cycle. It also flags whether the cycle accesses the array and whether the cycle is the first cycle of a burst opened by the processor strobe.

Writes are chosen by an active-low global write, an active-low byte-write enable and four active-low byte selects. Writes update the array at the clock edge. Reads are flow-through: the word at the address registered on the latest rising edge appears during the cycle that follows that edge, with no further pipeline stage.

The shared data bus is modelled as a separate input bus, an output bus and an output-drive flag. An asynchronous, active-low output-enable input gates that flag without waiting for a clock edge.

Top module: `sram_ft_core`

## Requirements
- R1: While reset is asserted, and after it is released until a read cycle has been registered, `dataOutEn` is low and `dataOut` is zero.
- R2: In an accessed, non-processor-start cycle with `globalWrN` low, all 36 bits of the addressed word take `dataIn`, whatever `byteWrEnN` and `byteSelN` say.
- R3: With `globalWrN` high and `byteWrEnN` low, each low `byteSelN[n]` writes `dataIn[8n+7:8n]` and parity bit `dataIn[32+n]`. The other lanes of the word keep their contents.
- R4: With `globalWrN` high and either `byteWrEnN` high or all four `byteSelN` high, the cycle is a read. The array is left unchanged.
- R5: A cycle with `procStart` high is always a read. Its write inputs are ignored.
- R6: An accessed cycle with `procStart` low and an active write decode performs the write at that same clock edge. A later read of the address returns the merged word.
- R7: In the cycle after a write edge, `dataOutEn` is low even when `outEnN` is low.
- R8: In the cycle after a read edge, `dataOutEn` equals the inverse of `outEnN` and follows it at once, without a clock edge. `dataOut` is zero whenever `dataOutEn` is low.
- R9: While `dataOutEn` is high, `dataOut` holds the word at the address registered on the most recent rising edge.
- R10: A cycle with `accessEn` low writes nothing. It also leaves `dataOutEn` low during the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| accessEn | input | 1 | Cycle accesses the array (start or burst continuation) |
| procStart | input | 1 | Cycle is a burst start opened by the processor strobe |
| addr | input | ADDR_W | Word address from the burst address generator |
| globalWrN | input | 1 | Global write, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| byteSelN | input | 4 | Per-lane byte selects, active low |
| dataIn | input | 36 | Write data: lanes in [31:0], parity in [35:32] |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dataOut | output | 36 | Read data, zero when not driving |
| dataOutEn | output | 1 | Bus drive flag; low means high impedance |

## Verification
Assertions check the following on every cycle:
- No write edge is followed by a driving cycle.
- A processor-start cycle always becomes a read.
- A deselected cycle never leads to a driving cycle.
- The address register tracks accessed cycles.
- Lane 0 of a written word holds the written byte.
- The output flag is never high while the output enable is high.

Only the bench scenarios can show the contents of the array:
- The merge of byte lanes with their parity bits.
- The global write overriding the byte selects.
- Read-only decode combinations leaving the array unchanged.
- The output flag reacting to the output enable in the middle of a cycle.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int WORD_W = DATA_W + LANES;

  typedef struct packed {
    logic             wrEn;
    logic [LANES-1:0] laneMask;
    logic             capture;
  } coreStrobe_t;
endpackage

// File: rtl/sram_ft_ctrl.sv
module sram_ft_ctrl
  import sram_ft_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             accessEn,
  input  logic             procStart,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] byteSelN,
  output coreStrobe_t      strb,
  output logic             rdActive
);
  logic [LANES-1:0] laneReq;
  logic             wrDetect;

  always_comb begin
    if (!globalWrN)      laneReq = '1;
    else if (!byteWrEnN) laneReq = ~byteSelN;
    else                 laneReq = '0;
    wrDetect      = accessEn && !procStart && (|laneReq);
    strb.wrEn     = wrDetect;
    strb.laneMask = wrDetect ? laneReq : '0;
    strb.capture  = accessEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdActive <= 1'b0;
    else       rdActive <= accessEn && !wrDetect;
  end

  // R7
  wr_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> !rdActive);

  // R5
  proc_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && procStart) |=> rdActive);

  // R10
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accessEn |=> !rdActive);
endmodule

// File: rtl/sram_ft_dpath.sv
module sram_ft_dpath
  import sram_ft_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  coreStrobe_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              rdActive,
  input  logic              outEnN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutEn
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] bitMask;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign bitMask[g*LANE_W +: LANE_W] = {LANE_W{strb.laneMask[g]}};
    assign bitMask[DATA_W + g]         = strb.laneMask[g];
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[addr] <= (mem[addr] & ~bitMask) | (dataIn & bitMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             addrReg <= '0;
    else if (strb.capture) addrReg <= addr;
  end

  assign dataOutEn = rdActive && !outEnN;
  assign dataOut   = dataOutEn ? mem[addrReg] : '0;

  // R9
  addr_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> addrReg == $past(addr));

  // R6
  wr_lane0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.laneMask[0]) |=>
      mem[$past(addr)][LANE_W-1:0] == $past(dataIn[LANE_W-1:0]));
endmodule

// File: rtl/sram_ft_core.sv
module sram_ft_core
  import sram_ft_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessEn,
  input  logic              procStart,
  input  logic [ADDR_W-1:0] addr,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  byteSelN,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutEn
);
  coreStrobe_t strb;
  logic        rdActive;

  sram_ft_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .procStart(procStart),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteSelN(byteSelN),
    .strb(strb), .rdActive(rdActive)
  );

  sram_ft_dpath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dataIn(dataIn),
    .rdActive(rdActive), .outEnN(outEnN), .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  always_comb begin
    // R8
    if (rstN && outEnN) oe_hiz_chk: assert (!dataOutEn);
  end
endmodule

// File: tb/sram_ft_core_tb.sv
module sram_ft_core_tb_top;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic          accessEn, procStart, globalWrN, byteWrEnN, outEnN;
  logic [AW-1:0] addr;
  logic [3:0]    byteSelN;
  logic [35:0]   dataIn;
  logic [35:0]   dataOut;
  logic          dataOutEn;
  logic [35:0]   refMem [DEPTH];
  int            checks = 0;
  int            errors = 0;

  always #2.5 clk = ~clk;

  sram_ft_core #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .procStart(procStart),
    .addr(addr), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .byteSelN(byteSelN), .dataIn(dataIn), .outEnN(outEnN),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] laneMerge(input logic [35:0] old, input logic [35:0] nw,
                                            input logic [3:0] lanes);
    logic [35:0] r = old;
    for (int n = 0; n < 4; n++)
      if (lanes[n]) begin
        r[8*n +: 8] = nw[8*n +: 8];
        r[32+n]     = nw[32+n];
      end
    return r;
  endfunction

  task automatic cyc(input logic acc, input logic ps, input logic gw, input logic bwe,
                     input logic [3:0] bs, input logic [AW-1:0] a, input logic [35:0] d);
    @(negedge clk);
    accessEn = acc; procStart = ps; globalWrN = gw; byteWrEnN = bwe;
    byteSelN = bs; addr = a; dataIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'hF, a, 36'h0);
    chk(req, {35'h0, dataOutEn}, 36'h1);
    chk(req, dataOut, refMem[a]);
  endtask

  task automatic tReset;
    rstN = 1'b0; outEnN = 1'b0;
    accessEn = 1'b0; procStart = 1'b0; globalWrN = 1'b1; byteWrEnN = 1'b1;
    byteSelN = 4'hF; addr = '0; dataIn = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {35'h0, dataOutEn}, 36'h0);
    chk("R1", dataOut, 36'h0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", {35'h0, dataOutEn}, 36'h0);
  endtask

  task automatic tGlobal;
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 10'd5, 36'hA_1234_5678);
    refMem[5] = 36'hA_1234_5678;
    chk("R7", {35'h0, dataOutEn}, 36'h0);
    rd(10'd5, "R2");
    // byte controls set to a single lane, global write still writes all
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'b1110, 10'd5, 36'h5_CAFE_F00D);
    refMem[5] = 36'h5_CAFE_F00D;
    rd(10'd5, "R2");
  endtask

  task automatic tByte;
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 10'd9, 36'h0_1122_3344);
    refMem[9] = 36'h0_1122_3344;
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, 10'd9, 36'hF_AABB_CCDD);
    refMem[9] = laneMerge(refMem[9], 36'hF_AABB_CCDD, 4'b0101);
    chk("R7", {35'h0, dataOutEn}, 36'h0);
    rd(10'd9, "R3");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 4'b0111, 10'd9, 36'h8_EE00_0000);
    refMem[9] = laneMerge(refMem[9], 36'h8_EE00_0000, 4'b1000);
    rd(10'd9, "R3");
  endtask

  task automatic tReadCombos;
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 10'd9, 36'h3_DEAD_BEEF);
    chk("R4", {35'h0, dataOutEn}, 36'h1);
    chk("R4", dataOut, refMem[9]);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 10'd9, 36'h3_DEAD_BEEF);
    chk("R4", dataOut, refMem[9]);
    rd(10'd9, "R4");
  endtask

  task automatic tProc;
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 10'd5, 36'h7_7777_7777);
    chk("R5", {35'h0, dataOutEn}, 36'h1);
    chk("R5", dataOut, refMem[5]);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 10'd5, 36'h7_7777_7777);
    refMem[5] = 36'h7_7777_7777;
    chk("R6", {35'h0, dataOutEn}, 36'h0);
    rd(10'd5, "R6");
  endtask

  task automatic tOutEn;
    rd(10'd9, "R8");
    outEnN = 1'b1; #1;
    chk("R8", {35'h0, dataOutEn}, 36'h0);
    chk("R8", dataOut, 36'h0);
    outEnN = 1'b0; #1;
    chk("R8", {35'h0, dataOutEn}, 36'h1);
    chk("R8", dataOut, refMem[9]);
  endtask

  task automatic tDesel;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 10'd5, 36'h1_0000_0001);
    chk("R10", {35'h0, dataOutEn}, 36'h0);
    chk("R10", dataOut, 36'h0);
    rd(10'd5, "R10");
  endtask

  task automatic tFlow;
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 10'd1023, 36'h2_0BAD_C0DE);
    refMem[1023] = 36'h2_0BAD_C0DE;
    rd(10'd5,    "R9");
    rd(10'd1023, "R9");
    rd(10'd9,    "R9");
  endtask

  initial begin
    tReset;
    tGlobal;
    tByte;
    tReadCombos;
    tProc;
    tOutEn;
    tDesel;
    tFlow;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule